// File: doc/BRIEF.md
# Compare Timer Bank with Latched Match Status

This block holds six independent general-purpose timers behind a flat, single-cycle register port. Each channel has a control word, a 32-bit up-counter, a compare word and one status flag. A channel that is enabled, and is not in free-run mode, sets its status flag in every cycle where its counter equals its compare value. This happens whether or not the channel's interrupt is unmasked. One interrupt line is the OR of every channel whose status and interrupt-enable bits are both set. A shared acknowledge word clears status bits; writing a one clears that bit.

All counters advance on a common tick qualifier. The block does not prescale the tick. Counter and compare both reset to zero. An enable written before either value is programmed therefore produces a match and latches status. That flag fires the interrupt the moment software unmasks the channel. Drivers must clear or acknowledge such a stale flag before they unmask.

Top module: `cmpt_bank`

## Requirements
- R1: After reset every control, counter, compare, interrupt-enable and status value reads zero and `irq_o` is low.
- R2: In each cycle that a channel is enabled, is not in mode 3, and has counter equal to compare, its status bit (word 25, bit k for channel k) is set on the following edge, whatever its interrupt-enable bit holds.
- R3: Enabling a channel whose counter and compare still hold their reset value of zero latches its status bit, which reads 1 two cycles after the enabling write.
- R4: `irq_o` is high exactly when some channel has both status and interrupt enable (word 24, bit k) set; writing an enable bit for an already-pending channel raises `irq_o` in the next cycle without any new match.
- R5: A write to word 26 clears every status bit whose data bit is 1 and leaves bits written 0 unchanged; writing 0x3F clears all six.
- R6: When an acknowledge and a match hit the same channel in the same cycle, the status bit stays set.
- R7: Control word bit 0 is enable, bit 1 is a clear strobe that zeroes the counter and reads back 0, and bits 5:4 select the mode; writing 0x2 stops the channel and zeroes its count.
- R8: An enabled channel's counter rises by one on each cycle with `tick_i` high and wraps from 0xFFFFFFFF to 0; a disabled channel's counter holds.
- R9: Channel k's control, counter and compare sit at words 4k, 4k+1 and 4k+2; counter and compare are writable while disabled and read back their current values.
- R10: In mode 0 (one-shot), a match clears the channel's enable bit on the next edge.
- R11: In mode 1 (repeat), a tick in a matching cycle loads the counter with zero, giving a period of compare+1 ticks.
- R12: In mode 2 (keep-going), the counter keeps counting past the match value.
- R13: In mode 3 (free-run), the channel never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Common count qualifier for all channels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest condition to create is an acknowledge landing on a channel in the same cycle that the channel still matches. The stimulus creates it by enabling a keep-going channel while the tick is held low, so that counter and compare stay equal at zero. Each acknowledge then coincides with a live match. A further hard case is the stale flag from an unprogrammed enable. The bench enables a channel with its interrupt masked, confirms that the line stays quiet, and then unmasks the channel. The behavioural model checks every register and the interrupt line on every clock.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'd0,
        MODE_REPEAT  = 2'd1,
        MODE_KEEP    = 2'd2,
        MODE_FREE    = 2'd3
    } cmpt_mode_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;
    localparam int CH_STRIDE     = 4;

endpackage

// File: rtl/cmpt_channel.sv
module cmpt_channel
    import cmpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ctrl_we_i,
    input  logic             cnt_we_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             match_o,
    output logic [CNT_W-1:0] ctrl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o
);

    typedef struct packed {
        logic             en;
        cmpt_mode_e       mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      match;

    always_comb begin
        st_d  = st_q;
        match = st_q.en && (st_q.mode != MODE_FREE) && (st_q.cnt == st_q.cmp);

        if (st_q.en && tick_i) begin
            if (match && st_q.mode == MODE_REPEAT) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (match && st_q.mode == MODE_ONESHOT) begin
            st_d.en = 1'b0;
        end

        if (ctrl_we_i) begin
            st_d.en   = wdata_i[CTRL_EN_BIT];
            st_d.mode = cmpt_mode_e'(wdata_i[CTRL_MODE_LSB +: 2]);
            if (wdata_i[CTRL_CLR_BIT]) begin
                st_d.cnt = '0;
            end
        end
        if (cnt_we_i) begin
            st_d.cnt = wdata_i;
        end
        if (cmp_we_i) begin
            st_d.cmp = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, mode: MODE_ONESHOT, cnt: '0, cmp: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_o                         = '0;
        ctrl_o[CTRL_EN_BIT]            = st_q.en;
        ctrl_o[CTRL_MODE_LSB +: 2]     = st_q.mode;
    end
    assign cnt_o   = st_q.cnt;
    assign cmp_o   = st_q.cmp;
    assign match_o = match;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && wdata_i[CTRL_CLR_BIT] && !cnt_we_i) |=> (st_q.cnt == '0)); // R7

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !ctrl_we_i && !cnt_we_i) |=> $stable(st_q.cnt)); // R8

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && st_q.mode == MODE_ONESHOT && !ctrl_we_i) |=> !st_q.en); // R10

    AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && st_q.mode == MODE_REPEAT && tick_i && !ctrl_we_i && !cnt_we_i)
        |=> (st_q.cnt == '0)); // R11

endmodule

// File: rtl/cmpt_irq.sv
module cmpt_irq #(
    parameter int N_CH = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ie_we_i,
    input  logic            ack_we_i,
    input  logic [N_CH-1:0] wbits_i,
    input  logic [N_CH-1:0] match_i,
    output logic [N_CH-1:0] status_o,
    output logic [N_CH-1:0] ie_o,
    output logic            irq_o
);

    typedef struct packed {
        logic [N_CH-1:0] ie;
        logic [N_CH-1:0] status;
    } irq_state_t;

    irq_state_t rq_d, rq_q;
    logic [N_CH-1:0] ack_mask;

    always_comb begin
        rq_d     = rq_q;
        ack_mask = ack_we_i ? wbits_i : '0;
        rq_d.status = (rq_q.status & ~ack_mask) | match_i;
        if (ie_we_i) begin
            rq_d.ie = wbits_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_q <= '0;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign status_o = rq_q.status;
    assign ie_o     = rq_q.ie;
    assign irq_o    = |(rq_q.status & rq_q.ie);

    AST_MATCH_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i != '0) |=> ((status_o & $past(match_i)) == $past(match_i))); // R2

    AST_UNMASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_we_i && ((wbits_i & status_o) != '0)) |=> irq_o); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we_i |=> ((status_o & $past(wbits_i) & ~$past(match_i)) == '0)); // R5

    AST_MATCH_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we_i && ((wbits_i & match_i) != '0))
        |=> ((status_o & $past(wbits_i & match_i)) == $past(wbits_i & match_i))); // R6

endmodule

// File: rtl/cmpt_bank.sv
module cmpt_bank
    import cmpt_pkg::*;
#(
    parameter int  N_CH   = 6,
    parameter int  CNT_W  = 32,
    localparam int ADDR_W = $clog2(N_CH * CH_STRIDE + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o
);

    localparam int GLB_BASE = N_CH * CH_STRIDE;
    localparam logic [ADDR_W-1:0] A_IE  = ADDR_W'(GLB_BASE);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(GLB_BASE + 1);
    localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(GLB_BASE + 2);

    logic [N_CH-1:0]  match;
    logic [N_CH-1:0]  status;
    logic [N_CH-1:0]  ie;
    logic [CNT_W-1:0] ctrl_rd [N_CH];
    logic [CNT_W-1:0] cnt_rd  [N_CH];
    logic [CNT_W-1:0] cmp_rd  [N_CH];

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(k * CH_STRIDE);
        localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(k * CH_STRIDE + 1);
        localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(k * CH_STRIDE + 2);

        cmpt_channel #(.CNT_W(CNT_W)) i_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_i),
            .ctrl_we_i (wr_en_i && addr_i == A_CTRL),
            .cnt_we_i  (wr_en_i && addr_i == A_CNT),
            .cmp_we_i  (wr_en_i && addr_i == A_CMP),
            .wdata_i   (wdata_i),
            .match_o   (match[k]),
            .ctrl_o    (ctrl_rd[k]),
            .cnt_o     (cnt_rd[k]),
            .cmp_o     (cmp_rd[k])
        );
    end

    cmpt_irq #(.N_CH(N_CH)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie_we_i  (wr_en_i && addr_i == A_IE),
        .ack_we_i (wr_en_i && addr_i == A_ACK),
        .wbits_i  (wdata_i[N_CH-1:0]),
        .match_i  (match),
        .status_o (status),
        .ie_o     (ie),
        .irq_o    (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < N_CH; k++) begin
            if (addr_i == ADDR_W'(k * CH_STRIDE))     rdata_o = ctrl_rd[k];
            if (addr_i == ADDR_W'(k * CH_STRIDE + 1)) rdata_o = cnt_rd[k];
            if (addr_i == ADDR_W'(k * CH_STRIDE + 2)) rdata_o = cmp_rd[k];
        end
        if (addr_i == A_IE) rdata_o = CNT_W'(ie);
        if (addr_i == A_ST) rdata_o = CNT_W'(status);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o)); // R1

endmodule

// File: tb/test_cmpt_bank.sv
`timescale 1ns/1ps
module test_cmpt_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cmpt_bank i_cmpt_bank (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // behavioural reference model
    bit          m_en   [6];
    int          m_mode [6];
    logic [31:0] m_cnt  [6];
    logic [31:0] m_cmp  [6];
    logic [5:0]  m_st;
    logic [5:0]  m_ie;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) begin
                m_en[k] = 0; m_mode[k] = 0; m_cnt[k] = 0; m_cmp[k] = 0;
            end
            m_st = 0; m_ie = 0;
        end else begin
            bit hit [6];
            for (int k = 0; k < 6; k++) begin
                hit[k] = m_en[k] && m_mode[k] != 3 && m_cnt[k] == m_cmp[k];
            end
            for (int k = 0; k < 6; k++) begin
                bit acked;
                acked = wr_en_i && addr_i == 26 && wdata_i[k];
                m_st[k] = (m_st[k] && !acked) || hit[k];
                if (m_en[k] && tick_i)
                    m_cnt[k] = (hit[k] && m_mode[k] == 1) ? 32'd0 : m_cnt[k] + 32'd1;
                if (hit[k] && m_mode[k] == 0) m_en[k] = 0;
            end
            if (wr_en_i) begin
                if (addr_i < 24) begin
                    int k;
                    k = addr_i / 4;
                    case (addr_i % 4)
                        0: begin
                            m_en[k] = wdata_i[0];
                            m_mode[k] = int'(wdata_i[5:4]);
                            if (wdata_i[1]) m_cnt[k] = 0;
                        end
                        1: m_cnt[k] = wdata_i;
                        2: m_cmp[k] = wdata_i;
                        default: ;
                    endcase
                end else if (addr_i == 24) begin
                    m_ie = wdata_i[5:0];
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] a);
        if (a < 24) begin
            int k;
            k = a / 4;
            case (a % 4)
                0: return {26'd0, 2'(m_mode[k]), 3'd0, m_en[k]};
                1: return m_cnt[k];
                2: return m_cmp[k];
                default: return 32'd0;
            endcase
        end
        if (a == 24) return {26'd0, m_ie};
        if (a == 25) return {26'd0, m_st};
        return 32'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            chk("R4 irq", {31'd0, irq_o}, {31'd0, |(m_st & m_ie)});
            if (addr_i < 24 && addr_i % 4 == 0)      tag = "R10 ctrl";
            else if (addr_i < 24 && addr_i % 4 == 1) tag = "R8 counter";
            else if (addr_i < 24)                    tag = "R9 compare";
            else if (addr_i == 25)                   tag = "R2 status";
            else                                     tag = "R4 enable";
            chk(tag, rdata_o, m_read(addr_i));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        addr_i = a;
        @(negedge clk);
        d = rdata_o;
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_i = 1'b0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(5'd0, v);  chk("R1 ctrl0", v, 0);
        rd(5'd5, v);  chk("R1 cnt1", v, 0);
        rd(5'd10, v); chk("R1 cmp2", v, 0);
        rd(5'd25, v); chk("R1 status", v, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);

        // R3 enable unprogrammed channel 1 in one-shot with interrupt masked
        wr(5'd4, 32'h1);
        rd(5'd25, v); chk("R3 stale status", v, 32'h02);
        chk("R2 masked irq low", {31'd0, irq_o}, 0);
        rd(5'd4, v);  chk("R10 one-shot disabled", v, 0);

        // R4 unmask raises irq at once
        wr(5'd24, 32'h02);
        chk("R4 irq on unmask", {31'd0, irq_o}, 1);

        // R5 ack zero has no effect, ack 0x3F clears all
        wr(5'd26, 32'h0);
        rd(5'd25, v); chk("R5 ack zero", v, 32'h02);
        wr(5'd26, 32'h3F);
        rd(5'd25, v); chk("R5 ack all", v, 0);
        chk("R5 irq low", {31'd0, irq_o}, 0);

        // R6 channel 2 keep-going, matching continuously, ack loses
        wr(5'd8, 32'h21);
        wr(5'd26, 32'h04);
        rd(5'd25, v); chk("R6 match beats ack", v, 32'h04);
        wr(5'd8, 32'h02);
        wr(5'd26, 32'h04);
        rd(5'd25, v); chk("R7 status clears after stop", v, 0);

        // R8 and R13 channel 0 free-run counting and wrap
        wr(5'd0, 32'h31);
        ticks(10);
        rd(5'd1, v);  chk("R8 count ten", v, 10);
        rd(5'd25, v); chk("R13 free-run no status", v, 0);
        wr(5'd1, 32'hFFFF_FFFF);
        ticks(1);
        rd(5'd1, v);  chk("R8 wrap", v, 0);
        wr(5'd0, 32'h0);

        // R11 channel 3 repeat with compare 3
        wr(5'd14, 32'd3);
        rd(5'd14, v); chk("R9 compare readback", v, 3);
        wr(5'd12, 32'h11);
        ticks(20);
        rd(5'd13, v); chk("R11 repeat count", v, 0);
        rd(5'd25, v); chk("R11 repeat status", v, 32'h08);
        wr(5'd12, 32'h0);
        wr(5'd26, 32'h3F);

        // R12 channel 4 keep-going past compare 2
        wr(5'd18, 32'd2);
        wr(5'd16, 32'h21);
        ticks(6);
        rd(5'd17, v); chk("R12 keep-going count", v, 6);
        rd(5'd25, v); chk("R12 status", v, 32'h10);

        // R7 clear with disable
        wr(5'd16, 32'h02);
        rd(5'd16, v); chk("R7 ctrl after clear", v, 0);
        rd(5'd17, v); chk("R7 counter zero", v, 0);
        ticks(3);
        rd(5'd17, v); chk("R8 held while off", v, 0);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule